// File: doc/BRIEF.md
# Temperature Sensor Register Bank

This block is the register file behind a byte-data management-bus target of a remote temperature sensor. A bus agent in front of it turns bus transactions into single-cycle read and write strobes carrying an 8-bit register address. The block takes unsigned fixed-point samples from an on-die sensor. Each sample has 8 integer bits and 3 fraction bits, which gives 0.125 degree steps from 0 to 255.875. A programmable signed offset is added to each sample. The result is limited to the legal range and published as an integer byte and a fraction byte.

A two-byte read of the current temperature is atomic. The first byte read, called the trigger, captures the whole value into a snapshot. The second byte then comes from that snapshot. While the pair is open, no new sample is taken. A configuration bit chooses which byte is the trigger. Programmable high and low limits are compared against the live value on all 11 bits, and the results show as alert flags in a status register. A rate register sets how often a new sample is taken.

Top module: `tsense_regs`

## Requirements
- R1: After reset the registers read as follows: high limit 0xFF at 0x07 and 0xE0 at 0x13. Low limit, offset (0x11, 0x12), configuration (0x03), rate (0x04) and status (0x02) all read 0x00.
- R2: Read data appears on rdata_o one cycle after the read strobe and holds until the next read. Address 0x01 returns the temperature integer byte. Address 0x10 returns the fraction in bits 7:5, with bits 4:0 reading 0.
- R3: When configuration bit 5 is 0, reading 0x01 captures the value. A following read of 0x10 returns the fraction of that captured sample, even if the sensor has changed since.
- R4: When configuration bit 5 is 1, reading 0x10 captures the value. A following read of 0x01 returns the integer of that captured sample.
- R5: Between the trigger read and the second read, the live value is not updated from the sensor. The status flags therefore stay on the old value until the pair completes.
- R6: The limit bytes are plain read/write storage: 0x07 and 0x08 hold the high and low integer, and 0x13 and 0x14 hold the high and low fraction. Fraction registers keep only bits 7:5 and read 0 in bits 4:0.
- R7: Status bit 4 is 1 exactly when the live 11-bit value is strictly above the high limit.
- R8: Status bit 3 is 1 exactly when the live 11-bit value is strictly below the low limit. All other status bits read 0.
- R9: The offset is held at 0x11 (integer, two's complement) and 0x12 (fraction in bits 7:5). It is added to the sample as a signed 11-bit value. The sum is clamped to 0 and to 255.875.
- R10: Bits 2:0 of the rate register (0x04) hold an exponent r. A new sample is taken once every 2^r cycles.
- R11: Reads of unmapped addresses return 0x00. Address 0xFF returns the constant revision 0x04. Writes to 0x01, 0x02, 0x10 and 0xFF have no effect.
- R12: In the configuration register only bit 5 (read order) is stored; the other bits read 0. Writing the configuration register cancels an open pair read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| sensor_i | input | 11 | Raw sensor sample, 8.3 unsigned fixed point |

## Verification
The bench changes the sensor between the two reads of a pair, in both read orders. A design without the snapshot would then return a mixed pair. A design that kept sampling during the pair would move the alert flags too early.

Alerts are probed one step either side of the limit. This exposes a compare that is not strict, or one made on the integer byte alone. The offset is driven both negative and positive past the range ends, where a missing clamp would wrap.

The sampling period is measured from one observed update to the next. This catches a divider with a period off by one or off by a power of two. Writes to read-only addresses and reads of holes in the map are checked for stray effects.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int TEMP_W = 11;
  localparam int FRAC_W = 3;
  typedef logic [TEMP_W-1:0] temp_t;

  localparam logic [7:0] A_TINT  = 8'h01;
  localparam logic [7:0] A_STAT  = 8'h02;
  localparam logic [7:0] A_CFG   = 8'h03;
  localparam logic [7:0] A_RATE  = 8'h04;
  localparam logic [7:0] A_HINT  = 8'h07;
  localparam logic [7:0] A_LINT  = 8'h08;
  localparam logic [7:0] A_TFRAC = 8'h10;
  localparam logic [7:0] A_OINT  = 8'h11;
  localparam logic [7:0] A_OFRAC = 8'h12;
  localparam logic [7:0] A_HFRAC = 8'h13;
  localparam logic [7:0] A_LFRAC = 8'h14;
  localparam logic [7:0] A_REV   = 8'hFF;

  localparam int CFG_ORDER_BIT = 5;
  localparam int STAT_HI_BIT   = 4;
  localparam int STAT_LO_BIT   = 3;

  function automatic logic is_mapped(logic [7:0] a);
    return a inside {A_TINT, A_STAT, A_CFG, A_RATE, A_HINT, A_LINT,
                     A_TFRAC, A_OINT, A_OFRAC, A_HFRAC, A_LFRAC, A_REV};
  endfunction

  function automatic logic is_frac(logic [7:0] a);
    return a inside {A_TFRAC, A_OFRAC, A_HFRAC, A_LFRAC};
  endfunction
endpackage

// File: rtl/tsense_rate_div.sv
module tsense_rate_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask   = ~({CNT_W{1'b1}} << rate_i);
  assign tick_o = (cnt_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsense_adjust.sv
module tsense_adjust
  import tsense_pkg::*;
(
  input  temp_t raw_i,
  input  temp_t ofs_i,
  output temp_t adj_o
);
  localparam int SUM_W = TEMP_W + 2;

  logic signed [SUM_W-1:0] sum;

  assign sum = $signed({2'b00, raw_i}) + $signed({{2{ofs_i[TEMP_W-1]}}, ofs_i});

  always_comb begin
    if (sum[SUM_W-1])      adj_o = '0;
    else if (sum[TEMP_W])  adj_o = '1;
    else                   adj_o = sum[TEMP_W-1:0];
  end
endmodule

// File: rtl/tsense_alert.sv
module tsense_alert
  import tsense_pkg::*;
(
  input  temp_t live_i,
  input  temp_t hi_i,
  input  temp_t lo_i,
  output logic  hi_o,
  output logic  lo_o
);
  assign hi_o = live_i > hi_i;
  assign lo_o = live_i < lo_i;
endmodule

// File: rtl/tsense_regs.sv
module tsense_regs
  import tsense_pkg::*;
#(
  parameter int         RATE_W = 3,
  parameter logic [7:0] REV_ID = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [TEMP_W-1:0] sensor_i
);
  localparam int INT_W = TEMP_W - FRAC_W;
  localparam int PAD_W = 8 - FRAC_W;

  temp_t             live_q, snap_q, hi_q, lo_q, ofs_q, adj;
  logic              order_q, pending_q;
  logic [RATE_W-1:0] rate_q;
  logic [7:0]        rdata_q, rd_mux;
  logic              tick, hi_al, lo_al;
  logic              int_rd, frac_rd, trig_rd, second_rd, cfg_wr;

  tsense_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_q),
    .tick_o (tick)
  );

  tsense_adjust u_adj (
    .raw_i (sensor_i),
    .ofs_i (ofs_q),
    .adj_o (adj)
  );

  tsense_alert u_alert (
    .live_i (live_q),
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .hi_o   (hi_al),
    .lo_o   (lo_al)
  );

  assign int_rd    = rd_i && (addr_i == A_TINT);
  assign frac_rd   = rd_i && (addr_i == A_TFRAC);
  assign trig_rd   = order_q ? frac_rd : int_rd;
  assign second_rd = order_q ? int_rd : frac_rd;
  assign cfg_wr    = wr_i && (addr_i == A_CFG);

  // read mux; second byte of an open pair comes from the snapshot
  always_comb begin
    rd_mux = 8'h00;
    unique case (addr_i)
      A_TINT:  rd_mux = (order_q && pending_q) ? snap_q[TEMP_W-1:FRAC_W]
                                               : live_q[TEMP_W-1:FRAC_W];
      A_TFRAC: rd_mux = (!order_q && pending_q) ? {snap_q[FRAC_W-1:0], {PAD_W{1'b0}}}
                                                : {live_q[FRAC_W-1:0], {PAD_W{1'b0}}};
      A_STAT: begin
        rd_mux[STAT_HI_BIT] = hi_al;
        rd_mux[STAT_LO_BIT] = lo_al;
      end
      A_CFG:   rd_mux[CFG_ORDER_BIT] = order_q;
      A_RATE:  rd_mux[RATE_W-1:0] = rate_q;
      A_HINT:  rd_mux = hi_q[TEMP_W-1:FRAC_W];
      A_LINT:  rd_mux = lo_q[TEMP_W-1:FRAC_W];
      A_OINT:  rd_mux = ofs_q[TEMP_W-1:FRAC_W];
      A_HFRAC: rd_mux = {hi_q[FRAC_W-1:0], {PAD_W{1'b0}}};
      A_LFRAC: rd_mux = {lo_q[FRAC_W-1:0], {PAD_W{1'b0}}};
      A_OFRAC: rd_mux = {ofs_q[FRAC_W-1:0], {PAD_W{1'b0}}};
      A_REV:   rd_mux = REV_ID;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '1;
      lo_q    <= '0;
      ofs_q   <= '0;
      order_q <= 1'b0;
      rate_q  <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_CFG:   order_q <= wdata_i[CFG_ORDER_BIT];
        A_RATE:  rate_q <= wdata_i[RATE_W-1:0];
        A_HINT:  hi_q[TEMP_W-1:FRAC_W] <= wdata_i[INT_W-1:0];
        A_LINT:  lo_q[TEMP_W-1:FRAC_W] <= wdata_i[INT_W-1:0];
        A_OINT:  ofs_q[TEMP_W-1:FRAC_W] <= wdata_i[INT_W-1:0];
        A_HFRAC: hi_q[FRAC_W-1:0] <= wdata_i[7 -: FRAC_W];
        A_LFRAC: lo_q[FRAC_W-1:0] <= wdata_i[7 -: FRAC_W];
        A_OFRAC: ofs_q[FRAC_W-1:0] <= wdata_i[7 -: FRAC_W];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      snap_q    <= '0;
    end else if (cfg_wr) begin
      pending_q <= 1'b0;
    end else if (trig_rd) begin
      pending_q <= 1'b1;
      snap_q    <= live_q;
    end else if (second_rd) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 live_q <= '0;
    else if (tick && !pending_q) live_q <= adj;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tsense_regs_chk.sv
module tsense_regs_chk
  import tsense_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       pending_i,
  input logic       order_i,
  input temp_t      live_i,
  input temp_t      hi_i,
  input temp_t      lo_i
);
  AST_FRAC_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && is_frac(addr_i) |=> rdata_o[4:0] == 5'd0);  // R6

  AST_HOLD_IN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_i |=> $stable(live_i));  // R5

  AST_HI_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_STAT |=> rdata_o[STAT_HI_BIT] == $past(live_i > hi_i));  // R7

  AST_LO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == A_STAT |=> rdata_o[STAT_LO_BIT] == $past(live_i < lo_i));  // R8

  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !is_mapped(addr_i) |=> rdata_o == 8'h00);  // R11

  AST_CFG_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == A_CFG |=> order_i == $past(wdata_i[CFG_ORDER_BIT]) && !pending_i);  // R12
endmodule

bind tsense_regs tsense_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pending_i (pending_q),
  .order_i   (order_q),
  .live_i    (live_q),
  .hi_i      (hi_q),
  .lo_i      (lo_q)
);

// File: tb/sim_tsense_regs.sv
module sim_tsense_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic [10:0] sensor_i = 11'd0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tsense_regs u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .sensor_i (sensor_i)
  );

  // tasks are entered and left at a falling edge
  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    check(tag, d, exp);
  endtask

  task automatic set_temp(logic [10:0] v);
    sensor_i = v;
    idle(2);
  endtask

  task automatic t_reset;
    rd_chk("R1 high int", 8'h07, 8'hFF);
    rd_chk("R1 high frac", 8'h13, 8'hE0);
    rd_chk("R1 low int", 8'h08, 8'h00);
    rd_chk("R1 low frac", 8'h14, 8'h00);
    rd_chk("R1 offset int", 8'h11, 8'h00);
    rd_chk("R1 offset frac", 8'h12, 8'h00);
    rd_chk("R1 config", 8'h03, 8'h00);
    rd_chk("R1 rate", 8'h04, 8'h00);
    rd_chk("R1 status", 8'h02, 8'h00);
  endtask

  task automatic t_format;
    set_temp(11'd201);  // 25.125
    rd_chk("R2 int byte", 8'h01, 8'h19);
    rd_chk("R2 frac byte", 8'h10, 8'h20);
  endtask

  task automatic t_order0;
    set_temp(11'd201);
    rd_chk("R3 trigger int", 8'h01, 8'h19);
    sensor_i = 11'd246;  // 30.75
    idle(3);
    rd_chk("R3 latched frac", 8'h10, 8'h20);
    idle(2);
    rd_chk("R3 new int", 8'h01, 8'h1E);
    rd_chk("R3 new frac", 8'h10, 8'hC0);
  endtask

  task automatic t_hold;
    wr_reg(8'h07, 8'h1E);
    wr_reg(8'h13, 8'h00);
    set_temp(11'd200);
    rd_chk("R5 trigger int", 8'h01, 8'h19);
    sensor_i = 11'd250;
    idle(3);
    rd_chk("R5 status held", 8'h02, 8'h00);
    rd_chk("R5 second frac", 8'h10, 8'h00);
    idle(1);
    rd_chk("R5 status after pair", 8'h02, 8'h10);
    wr_reg(8'h07, 8'hFF);
    wr_reg(8'h13, 8'hE0);
  endtask

  task automatic t_order1;
    wr_reg(8'h03, 8'hFF);
    rd_chk("R12 only order bit", 8'h03, 8'h20);
    set_temp(11'd201);
    rd_chk("R4 trigger frac", 8'h10, 8'h20);
    sensor_i = 11'd246;
    idle(3);
    rd_chk("R4 latched int", 8'h01, 8'h19);
    idle(2);
    rd_chk("R4 new frac", 8'h10, 8'hC0);
    rd_chk("R4 new int", 8'h01, 8'h1E);
    // open a pair, then cancel it by a config write
    rd_chk("R12 trigger frac", 8'h10, 8'hC0);
    wr_reg(8'h03, 8'h00);
    sensor_i = 11'd201;
    idle(3);
    rd_chk("R12 pair cancelled", 8'h01, 8'h19);
    rd_chk("R12 pair cancelled frac", 8'h10, 8'h20);
  endtask

  task automatic t_alerts;
    wr_reg(8'h07, 8'h1E);
    wr_reg(8'h13, 8'h00);
    set_temp(11'd241);
    rd_chk("R7 above high", 8'h02, 8'h10);
    set_temp(11'd240);
    rd_chk("R7 equal high", 8'h02, 8'h00);
    wr_reg(8'h08, 8'h0A);
    wr_reg(8'h14, 8'h80);
    set_temp(11'd83);
    rd_chk("R8 below low", 8'h02, 8'h08);
    set_temp(11'd84);
    rd_chk("R8 equal low", 8'h02, 8'h00);
    wr_reg(8'h07, 8'hFF);
    wr_reg(8'h13, 8'hE0);
    wr_reg(8'h08, 8'h00);
    wr_reg(8'h14, 8'h00);
  endtask

  task automatic t_limits;
    wr_reg(8'h13, 8'hFF);
    wr_reg(8'h07, 8'h5A);
    rd_chk("R6 frac first", 8'h13, 8'hE0);
    rd_chk("R6 int second", 8'h07, 8'h5A);
    wr_reg(8'h14, 8'h7F);
    rd_chk("R6 low frac", 8'h14, 8'h60);
    wr_reg(8'h07, 8'hFF);
    wr_reg(8'h13, 8'hE0);
    wr_reg(8'h14, 8'h00);
    rd_chk("R6 low frac restored", 8'h14, 8'h00);
  endtask

  task automatic t_offset;
    wr_reg(8'h11, 8'h02);
    wr_reg(8'h12, 8'h80);
    set_temp(11'd201);
    rd_chk("R9 plus offset int", 8'h01, 8'h1B);
    rd_chk("R9 plus offset frac", 8'h10, 8'hA0);
    wr_reg(8'h11, 8'hE2);
    wr_reg(8'h12, 8'h00);
    set_temp(11'd201);
    rd_chk("R9 clamp zero int", 8'h01, 8'h00);
    rd_chk("R9 clamp zero frac", 8'h10, 8'h00);
    wr_reg(8'h11, 8'h64);
    set_temp(11'd2000);
    rd_chk("R9 clamp top int", 8'h01, 8'hFF);
    rd_chk("R9 clamp top frac", 8'h10, 8'hE0);
    wr_reg(8'h11, 8'h00);
  endtask

  task automatic t_map;
    set_temp(11'd201);
    rd_chk("R11 hole", 8'h05, 8'h00);
    rd_chk("R11 hole 0x80", 8'h80, 8'h00);
    rd_chk("R11 revision", 8'hFF, 8'h04);
    wr_reg(8'h01, 8'hAA);
    wr_reg(8'h10, 8'hFF);
    wr_reg(8'hFF, 8'h00);
    wr_reg(8'h02, 8'hFF);
    idle(1);
    rd_chk("R11 int ignores write", 8'h01, 8'h19);
    rd_chk("R11 frac ignores write", 8'h10, 8'h20);
    rd_chk("R11 revision ignores write", 8'hFF, 8'h04);
    rd_chk("R11 status ignores write", 8'h02, 8'h00);
  endtask

  task automatic t_rate;
    logic [7:0] d;
    int cnt;
    wr_reg(8'h07, 8'h1E);
    wr_reg(8'h13, 8'h00);
    wr_reg(8'h04, 8'h03);
    rd_chk("R10 rate readback", 8'h04, 8'h03);
    sensor_i = 11'd400;
    d = 8'h00;
    for (int i = 0; i < 20 && d[4] == 1'b0; i++) rd_reg(8'h02, d);
    check("R10 first update seen", d, 8'h10);
    sensor_i = 11'd100;
    cnt = 0;
    for (int i = 0; i < 20 && d[4] == 1'b1; i++) begin
      rd_reg(8'h02, d);
      cnt++;
    end
    check("R10 period of 8", 8'(cnt), 8'd8);
    wr_reg(8'h04, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(1);
    t_reset;
    t_format;
    t_order0;
    t_hold;
    t_order1;
    t_alerts;
    t_limits;
    t_offset;
    t_map;
    t_rate;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule